// File: doc/BRIEF.md
# Boot partition address translator

This block sits in the request path between a storage command front end and a single flat backing store. The store holds two boot regions of equal size at its start, with the user area after them. Each incoming read or write request carries a block address relative to the partition the host has selected. The block adds the matching base offset and hands the physical block address to the store side. It picks that offset at run time from the partition-config byte, the configured boot region size and a mode pin that says whether the device runs as an embedded multimedia card.

Requests enter and leave over valid/ready interfaces with one register stage in between. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. Its translated form appears on the `phy_*` outputs after that edge and stays there, unchanged, until an edge where `phy_ready` is high. `req_ready` is high while the output register is empty or being drained, so back-pressure on the store side holds off new requests at once. The block also reports the user-area capacity. This is the store size minus the offset that is selected while reset is held, so the host never sees the boot regions as user space.

Top module: `boot_part_xlate`

## Requirements
- R1: While reset is held and after it is released, `phy_valid` is 0 and `req_ready` is 1 until a request is accepted.
- R2: While `phy_valid` is 1 and `phy_ready` is 0, `req_ready` is 0 and `phy_addr`, `phy_write` and `phy_err` hold their values.
- R3: When `mmc_mode` is 0 or `boot_size` is 0, the physical address equals the request address and `phy_err` is 0.
- R4: Otherwise, when the enable field `part_cfg[5:3]` is zero, the physical address equals the request address and `phy_err` is 0. Bits 7:6 of `part_cfg` never affect the result.
- R5: Otherwise, access field `part_cfg[2:0]` = 0 (user area) adds 2 × `boot_size` to the address.
- R6: Otherwise, access field value 1 (first boot region) adds nothing.
- R7: Otherwise, access field value 2 (second boot region) adds `boot_size`.
- R8: Otherwise, access field values 3 to 7 add nothing and set `phy_err` to 1 for that request.
- R9: `phy_write` repeats the request's `req_write`, and reads and writes get the same offset.
- R10: Each request is translated with the `mmc_mode`, `part_cfg` and `boot_size` present in the cycle it is accepted, so a change applies from the next accepted request on.
- R11: `user_cap` is loaded while reset is held with `store_blocks` minus the offset the R3–R8 rules give for the inputs at that time, clamped at 0. It then stays constant until the next reset.
- R12: Every accepted request produces exactly one result, valid in the cycle after the accepting edge. With no request, `phy_valid` drops once its result is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mmc_mode | input | 1 | 1 selects embedded card mode, where partition offsets apply |
| part_cfg | input | 8 | Partition-config byte: [5:3] enable, [2:0] access |
| boot_size | input | BSIZE_W | Size of each boot region in blocks |
| store_blocks | input | PHY_W | Total size of the backing store in blocks |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | ADDR_W | Partition-relative block address |
| req_write | input | 1 | 1 for write, 0 for read |
| phy_valid | output | 1 | Translated request present |
| phy_ready | input | 1 | Store side takes the translated request |
| phy_addr | output | PHY_W | Physical block address |
| phy_write | output | 1 | Write flag of the translated request |
| phy_err | output | 1 | Illegal access field seen for this request |
| user_cap | output | PHY_W | Reported user-area capacity in blocks |

## Verification
The hardest case to reach is a configuration change that lands while a request is stalled by back-pressure. The rule is that the translation must follow the config present at acceptance, not the config present when the request was first presented. The bench fills the output register, holds `phy_ready` low with a second request waiting, rewrites `part_cfg` during the stall and then releases it, so the waiting request must carry the new offset. The capacity clamp is reached by resetting with store sizes smaller than twice the boot region size.

// File: rtl/bpx_pkg.sv
package bpx_pkg;
  // Field layout of the partition-config byte
  localparam int ACC_LSB = 0;
  localparam int ACC_W   = 3;
  localparam int EN_LSB  = 3;
  localparam int EN_W    = 3;

  // Access field codes
  localparam logic [ACC_W-1:0] ACC_USER  = 3'd0;
  localparam logic [ACC_W-1:0] ACC_BOOTA = 3'd1;
  localparam logic [ACC_W-1:0] ACC_BOOTB = 3'd2;

  // Offset selection, expressed in boot-region units
  typedef enum logic [1:0] {
    OFS_ZERO = 2'd0,
    OFS_ONE  = 2'd1,
    OFS_TWO  = 2'd2,
    OFS_BAD  = 2'd3
  } ofs_kind_e;
endpackage

// File: rtl/bpx_cfg_decode.sv
module bpx_cfg_decode
  import bpx_pkg::*;
#(
  parameter int BSIZE_W = 16
) (
  input  logic               mmc_mode,
  input  logic [7:0]         part_cfg,
  input  logic [BSIZE_W-1:0] boot_size,
  output ofs_kind_e          kind
);
  logic [EN_W-1:0]  en_fld;
  logic [ACC_W-1:0] acc_fld;

  assign en_fld  = part_cfg[EN_LSB +: EN_W];
  assign acc_fld = part_cfg[ACC_LSB +: ACC_W];

  always_comb begin
    if (!mmc_mode || (boot_size == '0)) begin
      kind = OFS_ZERO;
    end else if (en_fld == '0) begin
      kind = OFS_ZERO;
    end else begin
      case (acc_fld)
        ACC_USER:  kind = OFS_TWO;
        ACC_BOOTA: kind = OFS_ZERO;
        ACC_BOOTB: kind = OFS_ONE;
        default:   kind = OFS_BAD;
      endcase
    end
  end
endmodule

// File: rtl/bpx_offset_gen.sv
module bpx_offset_gen
  import bpx_pkg::*;
#(
  parameter int BSIZE_W = 16,
  parameter int PHY_W   = 33
) (
  input  ofs_kind_e          kind,
  input  logic [BSIZE_W-1:0] boot_size,
  output logic [PHY_W-1:0]   offset,
  output logic               illegal
);
  localparam int PAD1 = PHY_W - BSIZE_W;
  localparam int PAD2 = PHY_W - BSIZE_W - 1;

  logic [PHY_W-1:0] one_sz;
  logic [PHY_W-1:0] two_sz;

  assign one_sz = {{PAD1{1'b0}}, boot_size};
  assign two_sz = {{PAD2{1'b0}}, boot_size, 1'b0};

  always_comb begin
    offset  = '0;
    illegal = 1'b0;
    case (kind)
      OFS_ONE: offset  = one_sz;
      OFS_TWO: offset  = two_sz;
      OFS_BAD: illegal = 1'b1;
      default: offset  = '0;
    endcase
  end
endmodule

// File: rtl/bpx_out_stage.sv
module bpx_out_stage #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  logic          vld_q;
  logic [DW-1:0] dat_q;

  assign in_ready  = !vld_q || out_ready;
  assign out_valid = vld_q;
  assign out_data  = dat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else if (in_ready) begin
      vld_q <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dat_q <= '0;
    end else if (in_ready && in_valid) begin
      dat_q <= in_data;
    end
  end
endmodule

// File: rtl/bpx_user_capacity.sv
module bpx_user_capacity #(
  parameter int PHY_W = 33
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PHY_W-1:0] store_blocks,
  input  logic [PHY_W-1:0] offset,
  output logic [PHY_W-1:0] user_cap
);
  logic [PHY_W-1:0] cap_q;
  logic [PHY_W-1:0] cap_d;

  assign cap_d    = (store_blocks > offset) ? (store_blocks - offset) : '0;
  assign user_cap = cap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_q <= cap_d;
    end
  end
endmodule

// File: rtl/boot_part_xlate.sv
module boot_part_xlate
  import bpx_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int BSIZE_W = 16,
  localparam int PHY_W  = ((ADDR_W > BSIZE_W + 1) ? ADDR_W : BSIZE_W + 1) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mmc_mode,
  input  logic [7:0]         part_cfg,
  input  logic [BSIZE_W-1:0] boot_size,
  input  logic [PHY_W-1:0]   store_blocks,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic               req_write,
  output logic               phy_valid,
  input  logic               phy_ready,
  output logic [PHY_W-1:0]   phy_addr,
  output logic               phy_write,
  output logic               phy_err,
  output logic [PHY_W-1:0]   user_cap
);
  localparam int DW    = PHY_W + 2;
  localparam int APAD  = PHY_W - ADDR_W;

  ofs_kind_e        kind;
  logic [PHY_W-1:0] offset;
  logic             illegal;
  logic [PHY_W-1:0] sum;
  logic [DW-1:0]    st_in;
  logic [DW-1:0]    st_out;

  bpx_cfg_decode #(.BSIZE_W(BSIZE_W)) i_dec (
    .mmc_mode (mmc_mode),
    .part_cfg (part_cfg),
    .boot_size(boot_size),
    .kind     (kind)
  );

  bpx_offset_gen #(.BSIZE_W(BSIZE_W), .PHY_W(PHY_W)) i_ofs (
    .kind     (kind),
    .boot_size(boot_size),
    .offset   (offset),
    .illegal  (illegal)
  );

  assign sum   = {{APAD{1'b0}}, req_addr} + offset;
  assign st_in = {illegal, req_write, sum};

  bpx_out_stage #(.DW(DW)) i_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (req_valid),
    .in_ready (req_ready),
    .in_data  (st_in),
    .out_valid(phy_valid),
    .out_ready(phy_ready),
    .out_data (st_out)
  );

  assign phy_addr  = st_out[PHY_W-1:0];
  assign phy_write = st_out[PHY_W];
  assign phy_err   = st_out[PHY_W+1];

  bpx_user_capacity #(.PHY_W(PHY_W)) i_cap (
    .clk         (clk),
    .rst_n       (rst_n),
    .store_blocks(store_blocks),
    .offset      (offset),
    .user_cap    (user_cap)
  );
endmodule

module bpx_checker #(
  parameter int ADDR_W  = 32,
  parameter int BSIZE_W = 16,
  parameter int PHY_W   = 33
) (
  input logic               clk,
  input logic               rst_n,
  input logic               mmc_mode,
  input logic [BSIZE_W-1:0] boot_size,
  input logic               req_valid,
  input logic               req_ready,
  input logic [ADDR_W-1:0]  req_addr,
  input logic               req_write,
  input logic               phy_valid,
  input logic               phy_ready,
  input logic [PHY_W-1:0]   phy_addr,
  input logic               phy_write,
  input logic               phy_err,
  input logic [PHY_W-1:0]   user_cap
);
  localparam int APAD = PHY_W - ADDR_W;

  // R2
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phy_valid && !phy_ready |=> phy_valid && $stable(phy_addr) && $stable(phy_write) && $stable(phy_err));

  // R2
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phy_valid && !phy_ready |-> !req_ready);

  // R12
  accept_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> phy_valid);

  // R3
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && (!mmc_mode || (boot_size == '0))
    |=> (phy_addr == {{APAD{1'b0}}, $past(req_addr)}) && !phy_err);

  // R8
  err_no_ofs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> (!phy_err || (phy_addr == {{APAD{1'b0}}, $past(req_addr)})));

  // R9
  write_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> (phy_write == $past(req_write)));

  // R11
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(user_cap));
endmodule

bind boot_part_xlate bpx_checker #(
  .ADDR_W(ADDR_W), .BSIZE_W(BSIZE_W), .PHY_W(PHY_W)
) i_bpx_checker (
  .clk(clk), .rst_n(rst_n), .mmc_mode(mmc_mode), .boot_size(boot_size),
  .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
  .req_write(req_write), .phy_valid(phy_valid), .phy_ready(phy_ready),
  .phy_addr(phy_addr), .phy_write(phy_write), .phy_err(phy_err),
  .user_cap(user_cap)
);

// File: tb/test_boot_part_xlate.sv
module test_boot_part_xlate;
  localparam int AW = 6;
  localparam int BW = 3;
  localparam int PW = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mmc_mode = 1'b0;
  logic [7:0]    part_cfg = '0;
  logic [BW-1:0] boot_size = '0;
  logic [PW-1:0] store_blocks = '0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic          req_write = 1'b0;
  logic          phy_valid;
  logic          phy_ready = 1'b1;
  logic [PW-1:0] phy_addr;
  logic          phy_write;
  logic          phy_err;
  logic [PW-1:0] user_cap;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  boot_part_xlate #(.ADDR_W(AW), .BSIZE_W(BW)) i_boot_part_xlate (
    .clk(clk), .rst_n(rst_n), .mmc_mode(mmc_mode), .part_cfg(part_cfg),
    .boot_size(boot_size), .store_blocks(store_blocks),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .phy_valid(phy_valid), .phy_ready(phy_ready),
    .phy_addr(phy_addr), .phy_write(phy_write), .phy_err(phy_err),
    .user_cap(user_cap)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected offset and error from the requirement rules
  function automatic int exp_ofs(input int md, input int bs, input int cfg);
    int acc;
    if (md == 0 || bs == 0) return 0;          // R3
    if (((cfg >> 3) & 7) == 0) return 0;       // R4
    acc = cfg & 7;
    if (acc == 0) return 2 * bs;               // R5
    if (acc == 2) return bs;                   // R7
    return 0;                                  // R6, R8
  endfunction

  function automatic bit exp_err(input int md, input int bs, input int cfg);
    if (md == 0 || bs == 0) return 1'b0;
    if (((cfg >> 3) & 7) == 0) return 1'b0;
    return (cfg & 7) > 2;
  endfunction

  function automatic string tag_of(input int md, input int bs, input int cfg);
    if (md == 0 || bs == 0) return "R3";
    if (((cfg >> 3) & 7) == 0) return "R4";
    case (cfg & 7)
      0: return "R5";
      1: return "R6";
      2: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic do_reset(input int md, input int bs, input int cfg, input int st);
    @(negedge clk);
    rst_n = 1'b0;
    req_valid = 1'b0;
    mmc_mode = md[0];
    boot_size = bs[BW-1:0];
    part_cfg = cfg[7:0];
    store_blocks = st[PW-1:0];
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Present one request at a negedge, check its result at the next negedge (R12)
  task automatic send_chk(input int md, input int bs, input int cfg, input int a, input bit w);
    int eo;
    int ea;
    bit ee;
    string tg;
    mmc_mode = md[0];
    boot_size = bs[BW-1:0];
    part_cfg = cfg[7:0];
    req_addr = a[AW-1:0];
    req_write = w;
    req_valid = 1'b1;
    @(negedge clk);
    eo = exp_ofs(md, bs, cfg & 8'h3f);
    ee = exp_err(md, bs, cfg & 8'h3f);
    ea = a + eo;
    tg = tag_of(md, bs, cfg & 8'h3f);
    check(phy_valid == 1'b1, "R12 valid", int'(phy_valid), 1);
    check(int'(phy_addr) == ea && phy_err == ee, tg, int'(phy_addr) + 1000 * int'(phy_err),
          ea + 1000 * int'(ee));
    check(phy_write == w, "R9 write flag", int'(phy_write), int'(w));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int st_list[3];
    st_list = '{0, 9, 100};

    // R1: reset state
    do_reset(0, 0, 0, 50);
    @(negedge clk);
    check(phy_valid == 1'b0, "R1 phy_valid after reset", int'(phy_valid), 0);
    check(req_ready == 1'b1, "R1 req_ready after reset", int'(req_ready), 1);
    check(int'(user_cap) == 50, "R11 capacity no offset", int'(user_cap), 50);

    // R11: capacity from reset-time config, clamped, held afterwards
    for (int md = 0; md < 2; md++)
      for (int bs = 0; bs < 8; bs++)
        for (int acc = 0; acc < 5; acc++)
          for (int si = 0; si < 3; si++) begin
            int cfg;
            int ec;
            cfg = (acc == 4) ? 8'h02 : (8'h08 | acc);
            do_reset(md, bs, cfg, st_list[si]);
            ec = st_list[si] - exp_ofs(md, bs, cfg);
            if (ec < 0) ec = 0;
            part_cfg = 8'h09;
            mmc_mode = 1'b1;
            boot_size = 3'd5;
            repeat (2) @(negedge clk);
            check(int'(user_cap) == ec, "R11 capacity", int'(user_cap), ec);
          end

    do_reset(1, 4, 8'h08, 100);
    @(negedge clk);

    // R3..R9 and R12: sweep of mode, boot size, config and addresses
    for (int md = 0; md < 2; md++)
      for (int bs = 0; bs < 8; bs++)
        for (int cfg = 0; cfg < 64; cfg++) begin
          int hi;
          hi = ((cfg + bs) & 1) ? 8'hc0 : 8'h40;   // R4: upper bits do not matter
          send_chk(md, bs, cfg | hi, (bs * 7 + cfg * 3 + md * 5) % 64, cfg[0]);
          send_chk(md, bs, cfg, 63, ~cfg[0]);
        end

    // R12: no request, result drained
    req_valid = 1'b0;
    @(negedge clk);
    check(phy_valid == 1'b0, "R12 drained", int'(phy_valid), 0);

    // R2 and R10: back-pressure with config change while a request waits
    mmc_mode = 1'b1;
    boot_size = 3'd3;
    part_cfg = 8'h0a;           // access 2: +3
    req_addr = 6'd10;
    req_write = 1'b1;
    req_valid = 1'b1;
    phy_ready = 1'b0;
    @(negedge clk);
    check(phy_valid && int'(phy_addr) == 13, "R7 first held request", int'(phy_addr), 13);
    req_addr = 6'd20;
    req_write = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(req_ready == 1'b0, "R2 req_ready under stall", int'(req_ready), 0);
      check(int'(phy_addr) == 13 && phy_write == 1'b1, "R2 output held",
            int'(phy_addr), 13);
    end
    part_cfg = 8'h08;           // access 0: +6, applied at acceptance
    @(negedge clk);
    check(int'(phy_addr) == 13, "R2 held after config change", int'(phy_addr), 13);
    phy_ready = 1'b1;
    @(negedge clk);
    check(int'(phy_addr) == 26 && phy_write == 1'b0, "R10 new config at acceptance",
          int'(phy_addr), 26);
    req_valid = 1'b0;
    @(negedge clk);
    check(phy_valid == 1'b0, "R12 single result", int'(phy_valid), 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule